// File: doc/BRIEF.md
# Chip-Select Window Address Decoder

This block maps an incoming 32-bit bus address onto one of eight external memory windows. Each window has a small configuration register that holds an enable bit, a 6-bit base that sets address bits 29:24, and a 4-bit mask over address bits 27:24. The mask sets the window size: each cleared mask bit doubles the span, from 16 MB with all four bits set up to 128 MB with only the top bit set. A parameter optionally admits an all-zero mask, which gives a 256 MB window.

A lookup is presented with `addrValid` and `addr`. One clock later the block reports a one-hot chip-select vector and the byte offset inside the selected window. Where enabled windows overlap, the lowest-numbered chip-select wins. A window whose mask is not one of the permitted patterns raises its bit in `maskErr` and never takes part in matching. The window registers are written through a simple indexed port and can be read back at any time.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every window register reads 0x00000F00, except chip-select 0, which reads 0x00000F40 (enabled, base 0, mask 0xF).
- R2: A register write keeps only bits 11:8 (mask) and 6:0 (bit 6 enable, bits 5:0 base); bit 7 and bits 31:12 always read back as zero.
- R3: An enabled window with a legal mask matches when addr[31:30] is zero, addr[29:28] equals base[5:4], and addr[27:24] equals base[3:0] at every position where the mask bit is one.
- R4: A window whose enable bit (bit 6) is clear never matches, whatever its base and mask.
- R5: On a hit, `offset` equals addr[23:0] together with addr[27:24] with the mask's set bits cleared; on a miss, `offset` is zero.
- R6: The legal masks are 0x8 (128 MB), 0xC (64 MB), 0xE (32 MB) and 0xF (16 MB); 0x0 (256 MB) is legal only when ALLOW_FULL_MASK is 1. An enabled window with any other mask sets its `maskErr` bit and never matches; a disabled window never sets `maskErr`.
- R7: When several enabled windows match, only the lowest-numbered chip-select is asserted in `csHit`; `csHit` is never more than one-hot.
- R8: `hitValid`, `csHit` and `offset` are registered and reflect the lookup presented one clock earlier; with no lookup, `hitValid` is low and `csHit` is zero.
- R9: A lookup that matches no window gives `hitValid` high with `csHit` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a window register |
| wrSel | input | SEL_W (3) | Index of the window register to write |
| wrData | input | 32 | Write data |
| rdSel | input | SEL_W (3) | Index of the window register to read |
| rdData | output | 32 | Read data of the selected window register |
| addrValid | input | 1 | A lookup address is presented |
| addr | input | 32 | Lookup address |
| hitValid | output | 1 | Result of a lookup is present |
| csHit | output | NUM_CS (8) | One-hot matched chip-select, zero on a miss |
| offset | output | 28 | Byte offset inside the matched window |
| maskErr | output | NUM_CS (8) | Enabled window with an illegal mask |

## Verification
A corrupted window register shows at once on `rdData` and on `maskErr`, and on the very next lookup as a wrong or missing chip-select bit. A fault in the priority pick appears as a wrong or multiple-hot `csHit` one cycle after the overlapping address is presented. An error in the mask handling shows either as a wrong window size, which is seen on the first address just past the window edge, or as a wrong `offset` top nibble on any hit. The lookup pipeline is one register deep, so every fault is visible within one clock of the lookup that exposes it.

// File: rtl/cswin_pkg.sv
package cswin_pkg;

  localparam int CFG_W    = 12;
  localparam int WIN_LSB  = 24;
  localparam int OFS_W    = 28;
  localparam int EN_BIT   = 6;

  localparam logic [CFG_W-1:0] KEEP_BITS = 12'hF7F;
  localparam logic [CFG_W-1:0] RST_CFG   = 12'hF00;

  typedef struct packed {
    logic wrLoad;
    logic capture;
  } csStrobe_t;

  function automatic logic maskLegal(input logic [3:0] m, input logic allowZero);
    case (m)
      4'h8, 4'hC, 4'hE, 4'hF: maskLegal = 1'b1;
      4'h0:                   maskLegal = allowZero;
      default:                maskLegal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cswin_ctrl.sv
module cswin_ctrl
  import cswin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      addrValid,
  output csStrobe_t strobe
);

  always_comb begin
    strobe         = '0;
    strobe.wrLoad  = wrEn & rstN;
    strobe.capture = addrValid & rstN;
  end

  p_no_strobe_in_reset_r8: assert property (@(posedge clk)
    !rstN |-> (strobe.wrLoad == 1'b0 && strobe.capture == 1'b0))
    else $error("strobe raised during reset");

endmodule

// File: rtl/cswin_datapath.sv
module cswin_datapath
  import cswin_pkg::*;
#(
  parameter int NUM_CS          = 8,
  parameter int SEL_W           = 3,
  parameter bit ALLOW_FULL_MASK = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobe_t         strobe,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [31:0]       wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [31:0]       rdData,
  input  logic [31:0]       addr,
  output logic              hitValid,
  output logic [NUM_CS-1:0] csHit,
  output logic [OFS_W-1:0]  offset,
  output logic [NUM_CS-1:0] maskErr
);

  logic [CFG_W-1:0]  cfgQ [NUM_CS];
  logic [NUM_CS-1:0] enVec;
  logic [NUM_CS-1:0] legalVec;
  logic [NUM_CS-1:0] matchVec;
  logic [NUM_CS-1:0] winVec;
  logic [3:0]        selMask;
  logic [OFS_W-1:0]  ofsNext;

  logic              hitValidQ;
  logic [NUM_CS-1:0] csHitQ;
  logic [OFS_W-1:0]  offsetQ;

  // per-window register and compare
  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    logic [3:0] winMask;
    logic [5:0] winBase;
    logic       hiOk;
    logic       loOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[g] <= (g == 0) ? (RST_CFG | (CFG_W'(1) << EN_BIT)) : RST_CFG;
      end else if (strobe.wrLoad && (wrSel == SEL_W'(g))) begin
        cfgQ[g] <= wrData[CFG_W-1:0] & KEEP_BITS;
      end
    end

    always_comb begin
      winMask     = cfgQ[g][11:8];
      winBase     = cfgQ[g][5:0];
      enVec[g]    = cfgQ[g][EN_BIT];
      legalVec[g] = maskLegal(winMask, ALLOW_FULL_MASK);
      hiOk        = (addr[31:30] == 2'b00) && (addr[29:28] == winBase[5:4]);
      loOk        = ((addr[27:24] ^ winBase[3:0]) & winMask) == 4'h0;
      matchVec[g] = enVec[g] && legalVec[g] && hiOk && loOk;
    end
  end

  assign maskErr = enVec & ~legalVec;

  // lowest index wins: isolate least significant set bit
  assign winVec = matchVec & (~matchVec + NUM_CS'(1));

  always_comb begin
    selMask = 4'h0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (winVec[i]) selMask = selMask | cfgQ[i][11:8];
    end
  end

  always_comb begin
    if (|winVec) ofsNext = {addr[27:24] & ~selMask, addr[WIN_LSB-1:0]};
    else         ofsNext = '0;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rdSel == SEL_W'(i)) rdData = {{(32-CFG_W){1'b0}}, cfgQ[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValidQ <= 1'b0;
      csHitQ    <= '0;
      offsetQ   <= '0;
    end else begin
      hitValidQ <= strobe.capture;
      csHitQ    <= strobe.capture ? winVec  : '0;
      offsetQ   <= strobe.capture ? ofsNext : '0;
    end
  end

  assign hitValid = hitValidQ;
  assign csHit    = csHitQ;
  assign offset   = offsetQ;

  p_onehot_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csHitQ))
    else $error("more than one chip-select asserted");

  p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|csHitQ) |-> hitValidQ)
    else $error("chip-select without valid result");

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> hitValidQ)
    else $error("result not presented one cycle after lookup");

  p_disabled_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ((csHitQ & ~$past(enVec)) == '0))
    else $error("disabled window matched");

  p_bad_mask_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ((csHitQ & $past(maskErr)) == '0))
    else $error("window with illegal mask matched");

  p_miss_zero_offset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csHitQ == '0) |-> (offsetQ == '0))
    else $error("offset nonzero on a miss");

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswin_pkg::*;
#(
  parameter int NUM_CS          = 8,
  parameter bit ALLOW_FULL_MASK = 1'b0,
  localparam int SEL_W          = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [31:0]       wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [31:0]       rdData,
  input  logic              addrValid,
  input  logic [31:0]       addr,
  output logic              hitValid,
  output logic [NUM_CS-1:0] csHit,
  output logic [27:0]       offset,
  output logic [NUM_CS-1:0] maskErr
);

  csStrobe_t strobe;

  cswin_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addrValid (addrValid),
    .strobe    (strobe)
  );

  cswin_datapath #(
    .NUM_CS          (NUM_CS),
    .SEL_W           (SEL_W),
    .ALLOW_FULL_MASK (ALLOW_FULL_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .addr     (addr),
    .hitValid (hitValid),
    .csHit    (csHit),
    .offset   (offset),
    .maskErr  (maskErr)
  );

endmodule

// File: tb/cs_window_decoder_bench.sv
`timescale 1ns/1ps
module cs_window_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdSel = '0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;

  logic [31:0] rdData, rdDataF;
  logic        hitValid, hitValidF;
  logic [7:0]  csHit, csHitF, maskErr, maskErrF;
  logic [27:0] offset, offsetF;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cs_window_decoder u_cs_window_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .addrValid(addrValid), .addr(addr),
    .hitValid(hitValid), .csHit(csHit), .offset(offset), .maskErr(maskErr)
  );

  cs_window_decoder #(.ALLOW_FULL_MASK(1'b1)) u_full (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdDataF), .addrValid(addrValid), .addr(addr),
    .hitValid(hitValidF), .csHit(csHitF), .offset(offsetF), .maskErr(maskErrF)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] sel, output logic [31:0] val);
    rdSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    addrValid = 1'b1; addr = a;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a,
                            input logic [7:0] expHit, input logic [27:0] expOfs);
    lookup(a);
    chk(req, "hitValid", {31'b0, hitValid}, 32'd1);
    chk(req, "csHit", {24'b0, csHit}, {24'b0, expHit});
    chk(req, "offset", {4'b0, offset}, {4'b0, expOfs});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      read_reg(3'(i), v);
      chk("R1", "reset value", v, (i == 0) ? 32'h0000_0F40 : 32'h0000_0F00);
    end
    chk("R8", "idle hitValid", {31'b0, hitValid}, 32'd0);
    chk("R8", "idle csHit", {24'b0, csHit}, 32'd0);
    chk("R6", "reset maskErr", {24'b0, maskErr}, 32'd0);
  endtask

  task automatic t_default_window();
    expect_hit("R3", 32'h00AB_CDEF, 8'h01, 28'h0AB_CDEF);
    expect_hit("R9", 32'h0100_0000, 8'h00, 28'h0);
  endtask

  task automatic t_write_mask_bits();
    logic [31:0] v;
    write_reg(3'd5, 32'hFFFF_FFFF);
    read_reg(3'd5, v);
    chk("R2", "masked write", v, 32'h0000_0F7F);
    expect_hit("R3", 32'h3F00_0010, 8'h20, 28'h000_0010);
    write_reg(3'd5, 32'h0000_0000);
    read_reg(3'd5, v);
    chk("R2", "cleared", v, 32'h0);
  endtask

  task automatic t_sizes();
    write_reg(3'd2, 32'h0000_0848);
    expect_hit("R5", 32'h0E12_3456, 8'h04, 28'h612_3456);
    expect_hit("R3", 32'h0712_3456, 8'h00, 28'h0);
    write_reg(3'd3, 32'h0000_0C54);
    expect_hit("R5", 32'h17FF_FFFF, 8'h08, 28'h3FF_FFFF);
    expect_hit("R3", 32'h1800_0000, 8'h00, 28'h0);
  endtask

  task automatic t_upper_bits();
    expect_hit("R3", 32'h4000_0100, 8'h00, 28'h0);
  endtask

  task automatic t_disabled();
    write_reg(3'd2, 32'h0000_0808);
    expect_hit("R4", 32'h0E12_3456, 8'h00, 28'h0);
  endtask

  task automatic t_priority();
    write_reg(3'd1, 32'h0000_0F40);
    expect_hit("R7", 32'h0000_0100, 8'h01, 28'h000_0100);
    write_reg(3'd0, 32'h0000_0F00);
    expect_hit("R7", 32'h0000_0100, 8'h02, 28'h000_0100);
    write_reg(3'd1, 32'h0000_0F00);
  endtask

  task automatic t_illegal_mask();
    write_reg(3'd4, 32'h0000_0A60);
    #1;
    chk("R6", "maskErr 0xA", {24'b0, maskErr}, 32'h10);
    expect_hit("R6", 32'h2000_0000, 8'h00, 28'h0);
    write_reg(3'd4, 32'h0000_0A20);
    #1;
    chk("R6", "maskErr disabled", {24'b0, maskErr}, 32'h0);
    write_reg(3'd4, 32'h0000_0060);
    #1;
    chk("R6", "mask 0 not allowed", {24'b0, maskErr}, 32'h10);
    chk("R6", "mask 0 allowed", {24'b0, maskErrF}, 32'h0);
    lookup(32'h2ABC_DEF0);
    chk("R6", "no hit mask 0", {24'b0, csHit}, 32'h0);
    chk("R6", "full hit", {24'b0, csHitF}, 32'h10);
    chk("R5", "full offset", {4'b0, offsetF}, 32'h0ABC_DEF0);
    write_reg(3'd4, 32'h0000_0F00);
  endtask

  task automatic t_no_lookup();
    @(negedge clk);
    @(negedge clk);
    chk("R8", "no lookup valid", {31'b0, hitValid}, 32'd0);
    chk("R8", "no lookup csHit", {24'b0, csHit}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_window();
    t_write_mask_bits();
    t_sizes();
    t_upper_bits();
    t_disabled();
    t_priority();
    t_illegal_mask();
    t_no_lookup();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule